// File: doc/BRIEF.md
# Outstanding Miss Tracker Entry

This block is one tracking slot of a non-blocking cache. It holds a single outstanding miss to one block address and the requests that have since arrived for that block. Those requests wait in one of two short target queues: a primary queue, served by the fill that is already on its way, and a deferred queue, for requests that the current downstream request cannot satisfy.

A slot is claimed by allocation. It is put in service when its request goes downstream and freed by deallocation. A slot that only forwarded a request and expects no reply frees itself when it is put in service. While the slot is busy, later CPU requests and snoops are appended as targets. Each target is tagged with its source, an order tag, a ready time and a pending flag. Each queue also keeps a flag that says whether any of its non-snoop targets needs an exclusive copy. The head of each queue is visible at the ports and is popped by the response logic.

Top module: `miss_track_entry`

## Requirements
- R1: After reset the slot is idle: busy, inService, pendInval, pendShared and downPend are 0, and priCount, defCount and tgtCount are 0.
- R2: Allocation is accepted only while the slot is idle. It clears both queues and puts one target at the head of the primary queue, with pending=1 and the given order and time. Its source code is 2'b10 (prefetcher) when allocPrefetch is set and 2'b00 (CPU) otherwise.
- R3: A request goes to the deferred queue, with pending=1, when the slot is in service and at least one of these holds: the deferred queue is non-empty, an invalidate is pending, or reqExcl is set while priExcl is clear.
- R4: Any other accepted request is appended to the primary queue with source 2'b00. Its pending flag is 1 before mark-in-service and 0 after.
- R5: Pushing a non-snoop target with its exclusive input set raises the exclusive flag of the queue it enters. Snoop targets never change either flag.
- R6: A snoop is appended to the primary queue with source 2'b01, its order tag and snpTime. It is pending only when downPend and priExcl are both set.
- R7: Mark-in-service on a slot allocated with allocFwdNoResp (which must hold exactly one target) frees the slot at the next edge: busy=0, inService=0, both counts 0.
- R8: reqReady is 0 while the slot is idle. A prefetch request to a busy slot is illegal.
- R9: tgtCount becomes 1 on allocation and rises by one for every accepted request or snoop. Pops leave it unchanged.
- R10: Each queue holds 4 targets. When the queue a request would enter is full, reqReady is 0 and nothing is stored. A snoop stalls (snpReady=0) when the primary queue is full.
- R11: Mark-in-service sets inService and loads downPend from markDownPend. Marking a slot that is already in service is an error.
- R12: A snoop accepted while in service sets pendInval when snpInval is set and pendShared when snpShared is set. Allocation and deallocation clear both flags.
- R13: Deallocation returns the slot to the R1 state.
- R14: Each queue is first-in first-out. A pop exposes the next-oldest target at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| allocValid | input | 1 | Claim the slot for a new miss |
| allocAddr | input | ADDR_W | Block address of the miss |
| allocPrefetch | input | 1 | The allocating request is a hardware prefetch |
| allocExcl | input | 1 | The allocating request needs an exclusive copy |
| allocFwdNoResp | input | 1 | Slot only forwards its request and expects no reply |
| allocOrder | input | ORD_W | Order tag of the first target |
| allocTime | input | TIME_W | Ready time of the first target |
| reqValid | input | 1 | A request hits this outstanding miss |
| reqPrefetch | input | 1 | The request is a prefetch (illegal while busy) |
| reqExcl | input | 1 | The request needs an exclusive copy |
| reqOrder | input | ORD_W | Order tag of the request |
| reqTime | input | TIME_W | Ready time of the request |
| reqReady | output | 1 | The request is accepted this cycle |
| snpValid | input | 1 | A snoop hits this outstanding miss |
| snpInval | input | 1 | The snoop invalidates |
| snpShared | input | 1 | The snoop leaves the block shared |
| snpOrder | input | ORD_W | Order tag of the snoop |
| snpTime | input | TIME_W | Current time, stored as the snoop's ready time |
| snpReady | output | 1 | The snoop can be accepted this cycle |
| markSvc | input | 1 | The slot's request was sent downstream |
| markDownPend | input | 1 | Downstream-pending value loaded on mark-in-service |
| dealloc | input | 1 | Free the slot |
| priPop | input | 1 | Remove the primary queue head |
| defPop | input | 1 | Remove the deferred queue head |
| busy | output | 1 | Slot holds a miss |
| inService | output | 1 | Slot's request is downstream |
| blockAddr | output | ADDR_W | Tracked block address |
| pendInval | output | 1 | An invalidate is pending |
| pendShared | output | 1 | A shared snoop is pending |
| downPend | output | 1 | Downstream-pending state |
| fwdOnly | output | 1 | Slot was allocated as forward-without-response |
| tgtCount | output | CNT_W | Accepted targets since allocation |
| priCount | output | CW | Primary queue occupancy |
| defCount | output | CW | Deferred queue occupancy |
| priExcl | output | 1 | Primary queue needs exclusive |
| defExcl | output | 1 | Deferred queue needs exclusive |
| priSrc | output | 2 | Source of primary head |
| priOrder | output | ORD_W | Order tag of primary head |
| priTime | output | TIME_W | Ready time of primary head |
| priPending | output | 1 | Pending flag of primary head |
| defSrc | output | 2 | Source of deferred head |
| defOrder | output | ORD_W | Order tag of deferred head |
| defTime | output | TIME_W | Ready time of deferred head |
| defPending | output | 1 | Pending flag of deferred head |

## Verification
A wrong exclusive flag or a stale pending-invalidate flag does not show at once. It shows one cycle after the next request, when defCount rises where priCount should have, or the reverse. The bench therefore follows each routing decision with a count check at the next edge. A wrong pending flag or source code shows only when that target reaches the queue head, so the bench pops down to it and reads the head fields. A counter or full-flag error appears as reqReady staying high with a full queue, or as tgtCount drifting away from the number of accepted pushes.

// File: rtl/miss_pkg.sv
package miss_pkg;
  parameter int ORD_W  = 8;
  parameter int TIME_W = 16;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'b00,
    SRC_SNOOP = 2'b01,
    SRC_PF    = 2'b10
  } srcKind_e;

  typedef struct packed {
    srcKind_e            src;
    logic [ORD_W-1:0]    order;
    logic [TIME_W-1:0]   readyAt;
    logic                pending;
  } target_t;

  // strobes from control to datapath; index 0 = primary, 1 = deferred
  typedef struct packed {
    logic       clear;
    logic [1:0] push;
    logic [1:0] pop;
    logic       exclIn;
    target_t    tgt;
  } pathCmd_t;
endpackage

// File: rtl/miss_tq.sv
module miss_tq
  import miss_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic          exclIn,
  input  target_t       din,
  output target_t       head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          needsExcl
);
  target_t    mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic       doPop;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign doPop = pop && !empty;
  assign head  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      needsExcl <= 1'b0;
    end else if (clear) begin
      rdPtr     <= '0;
      wrPtr     <= push ? PTR_W'(1) : '0;
      count     <= push ? CW'(1) : '0;
      needsExcl <= push && exclIn;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (push && !doPop) count <= count + 1'b1;
      else if (!push && doPop) count <= count - 1'b1;
      if (push && exclIn) needsExcl <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[clear ? '0 : wrPtr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (push && !clear) |-> !full); // R10
  AST_SNOOP_NO_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (push && din.src == SRC_SNOOP) |-> !exclIn); // R5
endmodule

// File: rtl/miss_path.sv
module miss_path
  import miss_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  pathCmd_t      cmd,
  output target_t       priHead,
  output target_t       defHead,
  output logic [CW-1:0] priCnt,
  output logic [CW-1:0] defCnt,
  output logic          priFull,
  output logic          defFull,
  output logic          defEmpty,
  output logic          priExclOut,
  output logic          defExclOut
);
  target_t       heads [2];
  logic [CW-1:0] cnts  [2];
  logic [1:0]    fulls, empties, excls;

  for (genvar g = 0; g < 2; g++) begin : g_list
    miss_tq #(.DEPTH(DEPTH)) i_tq (
      .clk       (clk),
      .rstN      (rstN),
      .clear     (cmd.clear),
      .push      (cmd.push[g]),
      .pop       (cmd.pop[g]),
      .exclIn    (cmd.exclIn && (cmd.tgt.src != SRC_SNOOP)),
      .din       (cmd.tgt),
      .head      (heads[g]),
      .count     (cnts[g]),
      .full      (fulls[g]),
      .empty     (empties[g]),
      .needsExcl (excls[g])
    );
  end

  assign priHead    = heads[0];
  assign defHead    = heads[1];
  assign priCnt     = cnts[0];
  assign defCnt     = cnts[1];
  assign priFull    = fulls[0];
  assign defFull    = fulls[1];
  assign defEmpty   = empties[1];
  assign priExclOut = excls[0];
  assign defExclOut = excls[1];

  logic unusedEmpty;
  assign unusedEmpty = empties[0];

  AST_ONE_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.push[0] && cmd.push[1])); // R3
endmodule

// File: rtl/miss_ctrl.sv
module miss_ctrl
  import miss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              allocPrefetch,
  input  logic              allocExcl,
  input  logic              allocFwdNoResp,
  input  logic [ORD_W-1:0]  allocOrder,
  input  logic [TIME_W-1:0] allocTime,
  input  logic              reqValid,
  input  logic              reqPrefetch,
  input  logic              reqExcl,
  input  logic [ORD_W-1:0]  reqOrder,
  input  logic [TIME_W-1:0] reqTime,
  output logic              reqReady,
  input  logic              snpValid,
  input  logic              snpInval,
  input  logic              snpShared,
  input  logic [ORD_W-1:0]  snpOrder,
  input  logic [TIME_W-1:0] snpTime,
  output logic              snpReady,
  input  logic              markSvc,
  input  logic              markDownPend,
  input  logic              dealloc,
  input  logic              priPop,
  input  logic              defPop,
  input  logic              priFull,
  input  logic              defFull,
  input  logic              defEmpty,
  input  logic              priExcl,
  output pathCmd_t          cmd,
  output logic              busy,
  output logic              inService,
  output logic [ADDR_W-1:0] blockAddr,
  output logic              pendInval,
  output logic              pendShared,
  output logic              downPend,
  output logic              fwdOnly,
  output logic [CNT_W-1:0]  tgtCount
);
  logic release_, allocGo, toDef, selFull, snpGo, reqGo, svcGo;

  assign release_ = busy && (dealloc || (markSvc && fwdOnly && !inService));
  assign allocGo  = allocValid && !busy;
  assign svcGo    = markSvc && busy && !inService && !release_;
  assign toDef    = inService && (!defEmpty || pendInval || (!priExcl && reqExcl));
  assign selFull  = toDef ? defFull : priFull;
  assign snpReady = busy && !release_ && !priFull;
  assign snpGo    = snpValid && snpReady;
  assign reqReady = busy && !release_ && !snpValid && !reqPrefetch && !selFull;
  assign reqGo    = reqValid && reqReady;

  always_comb begin
    cmd         = '0;
    cmd.clear   = allocGo || release_;
    cmd.push[0] = allocGo || snpGo || (reqGo && !toDef);
    cmd.push[1] = reqGo && toDef;
    cmd.pop     = {defPop, priPop};
    if (allocGo) begin
      cmd.tgt.src     = allocPrefetch ? SRC_PF : SRC_CPU;
      cmd.tgt.order   = allocOrder;
      cmd.tgt.readyAt = allocTime;
      cmd.tgt.pending = 1'b1;
      cmd.exclIn      = allocExcl;
    end else if (snpGo) begin
      cmd.tgt.src     = SRC_SNOOP;
      cmd.tgt.order   = snpOrder;
      cmd.tgt.readyAt = snpTime;
      cmd.tgt.pending = downPend && priExcl;
      cmd.exclIn      = 1'b0;
    end else begin
      cmd.tgt.src     = SRC_CPU;
      cmd.tgt.order   = reqOrder;
      cmd.tgt.readyAt = reqTime;
      cmd.tgt.pending = toDef || !inService;
      cmd.exclIn      = reqExcl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      inService  <= 1'b0;
      blockAddr  <= '0;
      pendInval  <= 1'b0;
      pendShared <= 1'b0;
      downPend   <= 1'b0;
      fwdOnly    <= 1'b0;
      tgtCount   <= '0;
    end else if (release_) begin
      busy       <= 1'b0;
      inService  <= 1'b0;
      pendInval  <= 1'b0;
      pendShared <= 1'b0;
      downPend   <= 1'b0;
      fwdOnly    <= 1'b0;
      tgtCount   <= '0;
    end else if (allocGo) begin
      busy       <= 1'b1;
      inService  <= 1'b0;
      blockAddr  <= allocAddr;
      pendInval  <= 1'b0;
      pendShared <= 1'b0;
      downPend   <= 1'b0;
      fwdOnly    <= allocFwdNoResp;
      tgtCount   <= CNT_W'(1);
    end else begin
      if (svcGo) begin
        inService <= 1'b1;
        downPend  <= markDownPend;
      end
      if (snpGo && inService) begin
        if (snpInval)  pendInval  <= 1'b1;
        if (snpShared) pendShared <= 1'b1;
      end
      if (snpGo || reqGo) tgtCount <= tgtCount + 1'b1;
    end
  end

  AST_NO_PF_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |-> !reqPrefetch); // R8
  AST_SVC_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && markSvc) |-> !inService); // R11
  AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && markSvc && fwdOnly) |-> (tgtCount == CNT_W'(1))); // R7
  AST_ALLOC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> !busy); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push != 2'b00 && !cmd.clear) |=> (tgtCount == CNT_W'($past(tgtCount) + 1'b1))); // R9
endmodule

// File: rtl/miss_track_entry.sv
module miss_track_entry
  import miss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              allocPrefetch,
  input  logic              allocExcl,
  input  logic              allocFwdNoResp,
  input  logic [ORD_W-1:0]  allocOrder,
  input  logic [TIME_W-1:0] allocTime,
  input  logic              reqValid,
  input  logic              reqPrefetch,
  input  logic              reqExcl,
  input  logic [ORD_W-1:0]  reqOrder,
  input  logic [TIME_W-1:0] reqTime,
  output logic              reqReady,
  input  logic              snpValid,
  input  logic              snpInval,
  input  logic              snpShared,
  input  logic [ORD_W-1:0]  snpOrder,
  input  logic [TIME_W-1:0] snpTime,
  output logic              snpReady,
  input  logic              markSvc,
  input  logic              markDownPend,
  input  logic              dealloc,
  input  logic              priPop,
  input  logic              defPop,
  output logic              busy,
  output logic              inService,
  output logic [ADDR_W-1:0] blockAddr,
  output logic              pendInval,
  output logic              pendShared,
  output logic              downPend,
  output logic              fwdOnly,
  output logic [CNT_W-1:0]  tgtCount,
  output logic [CW-1:0]     priCount,
  output logic [CW-1:0]     defCount,
  output logic              priExcl,
  output logic              defExcl,
  output logic [1:0]        priSrc,
  output logic [ORD_W-1:0]  priOrder,
  output logic [TIME_W-1:0] priTime,
  output logic              priPending,
  output logic [1:0]        defSrc,
  output logic [ORD_W-1:0]  defOrder,
  output logic [TIME_W-1:0] defTime,
  output logic              defPending
);
  pathCmd_t cmd;
  target_t  priHead, defHead;
  logic     priFull, defFull, defEmpty;

  miss_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocAddr(allocAddr), .allocPrefetch(allocPrefetch),
    .allocExcl(allocExcl), .allocFwdNoResp(allocFwdNoResp),
    .allocOrder(allocOrder), .allocTime(allocTime),
    .reqValid(reqValid), .reqPrefetch(reqPrefetch), .reqExcl(reqExcl),
    .reqOrder(reqOrder), .reqTime(reqTime), .reqReady(reqReady),
    .snpValid(snpValid), .snpInval(snpInval), .snpShared(snpShared),
    .snpOrder(snpOrder), .snpTime(snpTime), .snpReady(snpReady),
    .markSvc(markSvc), .markDownPend(markDownPend), .dealloc(dealloc),
    .priPop(priPop), .defPop(defPop),
    .priFull(priFull), .defFull(defFull), .defEmpty(defEmpty), .priExcl(priExcl),
    .cmd(cmd), .busy(busy), .inService(inService), .blockAddr(blockAddr),
    .pendInval(pendInval), .pendShared(pendShared), .downPend(downPend),
    .fwdOnly(fwdOnly), .tgtCount(tgtCount)
  );

  miss_path #(.DEPTH(DEPTH)) i_path (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .priHead(priHead), .defHead(defHead),
    .priCnt(priCount), .defCnt(defCount),
    .priFull(priFull), .defFull(defFull), .defEmpty(defEmpty),
    .priExclOut(priExcl), .defExclOut(defExcl)
  );

  assign priSrc     = priHead.src;
  assign priOrder   = priHead.order;
  assign priTime    = priHead.readyAt;
  assign priPending = priHead.pending;
  assign defSrc     = defHead.src;
  assign defOrder   = defHead.order;
  assign defTime    = defHead.readyAt;
  assign defPending = defHead.pending;
endmodule

// File: tb/test_miss_track_entry.sv
module test_miss_track_entry;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CW = 3;

  logic clk = 0, rstN = 0;
  logic allocValid = 0, allocPrefetch = 0, allocExcl = 0, allocFwdNoResp = 0;
  logic [ADDR_W-1:0] allocAddr = '0;
  logic [7:0] allocOrder = '0, reqOrder = '0, snpOrder = '0;
  logic [15:0] allocTime = '0, reqTime = '0, snpTime = '0;
  logic reqValid = 0, reqPrefetch = 0, reqExcl = 0;
  logic snpValid = 0, snpInval = 0, snpShared = 0;
  logic markSvc = 0, markDownPend = 0, dealloc = 0, priPop = 0, defPop = 0;
  logic reqReady, snpReady, busy, inService, pendInval, pendShared, downPend, fwdOnly;
  logic [ADDR_W-1:0] blockAddr;
  logic [7:0] tgtCount, priOrder, defOrder;
  logic [CW-1:0] priCount, defCount;
  logic priExcl, defExcl, priPending, defPending;
  logic [1:0] priSrc, defSrc;
  logic [15:0] priTime, defTime;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  miss_track_entry i_miss_track_entry (.*);

  task automatic chk(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    allocValid = 0; reqValid = 0; snpValid = 0; markSvc = 0;
    dealloc = 0; priPop = 0; defPop = 0;
  endtask

  task automatic doAlloc(bit pf, bit ex, bit fwd, int ord, int tm);
    allocValid = 1; allocPrefetch = pf; allocExcl = ex; allocFwdNoResp = fwd;
    allocOrder = 8'(ord); allocTime = 16'(tm); allocAddr = 32'h1000 + 32'(ord);
    step();
  endtask

  task automatic doReq(bit ex, int ord, int tm);
    reqValid = 1; reqExcl = ex; reqOrder = 8'(ord); reqTime = 16'(tm);
    step();
  endtask

  task automatic doSnp(bit inv, bit sh, int ord, int tm);
    snpValid = 1; snpInval = inv; snpShared = sh; snpOrder = 8'(ord); snpTime = 16'(tm);
    step();
  endtask

  task automatic doSvc(bit dp);
    markSvc = 1; markDownPend = dp; step();
  endtask

  task automatic doFree();
    dealloc = 1; step();
  endtask

  task automatic tReset();
    chk("R1 busy", busy, 0); chk("R1 inService", inService, 0);
    chk("R1 priCount", priCount, 0); chk("R1 defCount", defCount, 0);
    chk("R1 tgtCount", tgtCount, 0); chk("R1 pendInval", pendInval, 0);
    chk("R8 reqReady idle", reqReady, 0);
  endtask

  task automatic tRouting();
    doAlloc(0, 0, 0, 5, 100);
    chk("R2 busy", busy, 1); chk("R2 src", priSrc, 0); chk("R2 order", priOrder, 5);
    chk("R2 time", priTime, 100); chk("R2 pending", priPending, 1);
    chk("R9 count", tgtCount, 1); chk("R2 blockAddr", blockAddr, 32'h1005);
    reqValid = 1; reqExcl = 0; #1;
    chk("R4 ready", reqReady, 1);
    doReq(0, 6, 110);
    chk("R4 priCount", priCount, 2); chk("R14 head kept", priOrder, 5);
    priPop = 1; step();
    chk("R14 head next", priOrder, 6); chk("R4 pending before svc", priPending, 1);
    chk("R9 pop keeps count", tgtCount, 2);
    doSvc(1);
    chk("R11 inService", inService, 1); chk("R11 downPend", downPend, 1);
    doReq(0, 7, 120);
    chk("R4 primary", priCount, 2); chk("R3 def empty", defCount, 0);
    doReq(1, 8, 130);
    chk("R3 excl deferred", defCount, 1); chk("R3 primary unchanged", priCount, 2);
    chk("R3 def pending", defPending, 1); chk("R3 def src", defSrc, 0);
    chk("R5 defExcl", defExcl, 1); chk("R5 priExcl", priExcl, 0);
    doReq(0, 9, 140);
    chk("R3 nonempty deferred", defCount, 2);
    chk("R9 count", tgtCount, 5);
    priPop = 1; step();
    chk("R4 pending after svc", priPending, 0); chk("R4 order", priOrder, 7);
    defPop = 1; step();
    chk("R14 def next", defOrder, 9);
    doFree();
    chk("R13 busy", busy, 0); chk("R13 inService", inService, 0);
    chk("R13 priCount", priCount, 0); chk("R13 defCount", defCount, 0);
    chk("R13 count", tgtCount, 0); chk("R13 downPend", downPend, 0);
  endtask

  task automatic tSnoop();
    doAlloc(0, 1, 0, 1, 10);
    chk("R5 alloc excl", priExcl, 1);
    doSvc(1);
    doSnp(1, 1, 2, 50);
    chk("R12 pendInval", pendInval, 1); chk("R12 pendShared", pendShared, 1);
    chk("R6 priCount", priCount, 2);
    doReq(0, 3, 60);
    chk("R3 inval deferred", defCount, 1);
    priPop = 1; step();
    chk("R6 src", priSrc, 1); chk("R6 order", priOrder, 2); chk("R6 time", priTime, 50);
    chk("R6 pending", priPending, 1);
    doFree();
    chk("R12 cleared", pendInval, 0);
    doAlloc(1, 1, 0, 20, 5);
    chk("R2 pf src", priSrc, 2); chk("R5 pf excl", priExcl, 1);
    chk("R9 realloc count", tgtCount, 1);
    doFree();
    doAlloc(0, 0, 0, 30, 7);
    doSvc(0);
    chk("R11 downPend zero", downPend, 0);
    doSnp(0, 0, 31, 70);
    chk("R5 snoop no excl", priExcl, 0);
    priPop = 1; step();
    chk("R6 not pending", priPending, 0); chk("R12 no inval", pendInval, 0);
    doFree();
  endtask

  task automatic tFull();
    doAlloc(0, 0, 0, 40, 1);
    doReq(0, 41, 1); doReq(0, 42, 1); doReq(0, 43, 1);
    chk("R10 full count", priCount, 4);
    reqValid = 1; reqExcl = 0; #1;
    chk("R10 ready low", reqReady, 0); chk("R10 snp ready low", snpReady, 0);
    step();
    chk("R10 count held", priCount, 4); chk("R10 tgt held", tgtCount, 4);
    chk("R14 head oldest", priOrder, 40);
    doFree();
  endtask

  task automatic tForward();
    doAlloc(0, 0, 1, 50, 2);
    chk("R7 busy", busy, 1);
    doSvc(0);
    chk("R7 released", busy, 0); chk("R7 inService", inService, 0);
    chk("R7 priCount", priCount, 0);
    reqValid = 1; #1;
    chk("R8 ready idle", reqReady, 0);
    step();
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 2 + 1);
    tReset();
    rstN = 1;
    step();
    tRouting();
    tSnoop();
    tFull();
    tForward();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule